// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This block performs lane-parallel integer arithmetic on a pair of 32-bit operands. A format select splits each operand into one of three shapes: four unsigned bytes, two signed halfwords, or one signed word. Each lane is computed on its own. The operations are:

- wrapping add and subtract;
- saturating add and subtract;
- saturating absolute value;
- halving add and subtract, each with an optional round-up.

The result word and an overflow request are combinational. The overflow request is the OR of the lane overflow flags for the selected format only.

A small registered wrapper turns the overflow request into one sticky status bit. An operation updates the bit only when it is qualified by a valid strobe. The bit can only be set by operations. A synchronous clear input, or the asynchronous active-low reset, returns it to zero.

Top module: `pack_arith_unit`

## Requirements
- R1: `lane_fmt` selects the lane shape. 0 gives four unsigned byte lanes, 1 gives two signed halfword lanes, and 2 or 3 gives one signed word lane. Lane i occupies bits [i*W+W-1 : i*W], and each lane's result depends only on its own operand bits.
- R2: Opcode 0 (wrapping add) and opcode 2 (wrapping subtract) return the low W bits of the exact result. They raise `ovf_o` on an unsigned carry out or borrow, or when a signed result lies outside the lane's range.
- R3: Opcode 1 (saturating add) returns the exact sum when it fits. Otherwise an unsigned lane returns all ones, and a signed lane returns the largest positive or most negative value, whichever lies on the side of the true result. Either clamp raises `ovf_o`.
- R4: Opcode 3 (saturating subtract) returns the exact difference when it fits. Otherwise an unsigned lane that borrows returns zero, and a signed lane clamps to the largest positive or most negative value. Either clamp raises `ovf_o`.
- R5: Opcode 4 (absolute value) treats every lane as signed, in every format. The most negative value (0x80, 0x8000 or 0x80000000) becomes the largest positive value and raises `ovf_o`. Other negative values are negated, and non-negative values pass through.
- R6: The halving opcodes never raise `ovf_o`. Each returns floor(x/2) mod 2^W, where x is:

  | Opcode | Operation | x |
  |---|---|---|
  | 5 | halving add | a+b |
  | 6 | rounded halving add | a+b+1 |
  | 7 | halving subtract | a-b |
  | 8 | rounded halving subtract | a-b+1 |

  Operands are unsigned in byte format and signed otherwise.
- R7: Opcodes 9 to 15 return zero and never raise `ovf_o`.
- R8: `ovf_o` is the OR of the overflow flags of the lanes of the selected format only. A carry across a lane boundary of another format has no effect.
- R9: `sticky_o` becomes 1 at the clock edge that samples `op_valid`=1 with `ovf_o`=1. No operation ever clears it.
- R10: `sticky_o` is 0 after reset. `clr_sticky`=1 clears it at the next edge and takes priority over a simultaneous set.
- R11: An overflowing operation presented with `op_valid`=0 leaves `sticky_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Qualifies the operation for the sticky update |
| op_sel | input | 4 | Operation code |
| lane_fmt | input | 2 | Lane shape select |
| src_a | input | 32 | First operand word |
| src_b | input | 32 | Second operand word |
| clr_sticky | input | 1 | Synchronous clear of the sticky bit |
| res_o | output | 32 | Packed result word (combinational) |
| ovf_o | output | 1 | Overflow request of the current operation (combinational) |
| sticky_o | output | 1 | Registered sticky overflow status |

## Verification
The result word and the overflow request are due in the same cycle as the operands. The sticky bit is due one clock edge later. The driver applies each operation on a falling edge and pushes one expected item into a queue. The monitor pops that item two time units after the following rising edge. At that point the operands are still held, so the combinational outputs belong to that operation, and the sticky bit has just absorbed it. Each popped item therefore checks `res_o`, `ovf_o` and `sticky_o` together, against an integer-arithmetic model and a modelled sticky bit.

// File: rtl/pack_arith_pkg.sv
package pack_arith_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDS  = 4'd1,
        OP_SUB   = 4'd2,
        OP_SUBS  = 4'd3,
        OP_ABS   = 4'd4,
        OP_HADD  = 4'd5,
        OP_HADDR = 4'd6,
        OP_HSUB  = 4'd7,
        OP_HSUBR = 4'd8
    } pa_op_e;

    typedef struct packed {
        logic sticky;
    } pa_state_t;

endpackage

// File: rtl/pack_arith_lane.sv
module pack_arith_lane
    import pack_arith_pkg::*;
#(
    parameter int W   = 8,
    parameter bit SGN = 1'b0
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  pa_op_e       op_i,
    output logic [W-1:0] res_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W:0]   ONE  = {{W{1'b0}}, 1'b1};

    logic [W:0] ax, bx, sum, dif, sum_r, dif_r;
    logic       add_ov, sub_ov;

    always_comb begin
        ax     = SGN ? {a_i[W-1], a_i} : {1'b0, a_i};
        bx     = SGN ? {b_i[W-1], b_i} : {1'b0, b_i};
        sum    = ax + bx;
        dif    = ax - bx;
        sum_r  = sum + ONE;
        dif_r  = dif + ONE;
        // signed: top two extended bits disagree; unsigned: carry/borrow bit
        add_ov = SGN ? (sum[W] ^ sum[W-1]) : sum[W];
        sub_ov = SGN ? (dif[W] ^ dif[W-1]) : dif[W];

        res_o = '0;
        ovf_o = 1'b0;
        unique case (op_i)
            OP_ADD: begin
                res_o = sum[W-1:0];
                ovf_o = add_ov;
            end
            OP_ADDS: begin
                ovf_o = add_ov;
                if (!add_ov)  res_o = sum[W-1:0];
                else if (SGN) res_o = sum[W] ? SMIN : SMAX;
                else          res_o = '1;
            end
            OP_SUB: begin
                res_o = dif[W-1:0];
                ovf_o = sub_ov;
            end
            OP_SUBS: begin
                ovf_o = sub_ov;
                if (!sub_ov)  res_o = dif[W-1:0];
                else if (SGN) res_o = dif[W] ? SMIN : SMAX;
                else          res_o = '0;
            end
            OP_ABS: begin
                if (a_i == SMIN) begin
                    res_o = SMAX;
                    ovf_o = 1'b1;
                end else if (a_i[W-1]) begin
                    res_o = '0 - a_i;
                end else begin
                    res_o = a_i;
                end
            end
            OP_HADD:  res_o = W'(sum   >> 1);
            OP_HADDR: res_o = W'(sum_r >> 1);
            OP_HSUB:  res_o = W'(dif   >> 1);
            OP_HSUBR: res_o = W'(dif_r >> 1);
            default: begin
                res_o = '0;
                ovf_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pack_arith_core.sv
module pack_arith_core
    import pack_arith_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  pa_op_e            op_i,
    input  logic [1:0]        fmt_i,
    output logic [DATA_W-1:0] res_o,
    output logic              ovf_o
);
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int NB     = DATA_W / BYTE_W;
    localparam int NH     = DATA_W / HALF_W;

    logic [DATA_W-1:0] byte_res, half_res, word_res;
    logic [NB-1:0]     byte_ovf;
    logic [NH-1:0]     half_ovf;
    logic              word_ovf;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        pack_arith_lane #(.W(BYTE_W), .SGN(1'b0)) i_lane (
            .a_i  (a_i[i*BYTE_W +: BYTE_W]),
            .b_i  (b_i[i*BYTE_W +: BYTE_W]),
            .op_i (op_i),
            .res_o(byte_res[i*BYTE_W +: BYTE_W]),
            .ovf_o(byte_ovf[i])
        );
    end

    for (genvar i = 0; i < NH; i++) begin : g_half
        pack_arith_lane #(.W(HALF_W), .SGN(1'b1)) i_lane (
            .a_i  (a_i[i*HALF_W +: HALF_W]),
            .b_i  (b_i[i*HALF_W +: HALF_W]),
            .op_i (op_i),
            .res_o(half_res[i*HALF_W +: HALF_W]),
            .ovf_o(half_ovf[i])
        );
    end

    pack_arith_lane #(.W(DATA_W), .SGN(1'b1)) i_word (
        .a_i  (a_i),
        .b_i  (b_i),
        .op_i (op_i),
        .res_o(word_res),
        .ovf_o(word_ovf)
    );

    always_comb begin
        if (fmt_i[1]) begin
            res_o = word_res;
            ovf_o = word_ovf;
        end else if (fmt_i[0]) begin
            res_o = half_res;
            ovf_o = |half_ovf;
        end else begin
            res_o = byte_res;
            ovf_o = |byte_ovf;
        end
    end
endmodule

// File: rtl/pack_arith_unit.sv
module pack_arith_unit
    import pack_arith_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_sel,
    input  logic [1:0]        lane_fmt,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              clr_sticky,
    output logic [DATA_W-1:0] res_o,
    output logic              ovf_o,
    output logic              sticky_o
);
    pa_state_t st_d, st_q;

    pack_arith_core #(.DATA_W(DATA_W)) i_core (
        .a_i  (src_a),
        .b_i  (src_b),
        .op_i (pa_op_e'(op_sel)),
        .fmt_i(lane_fmt),
        .res_o(res_o),
        .ovf_o(ovf_o)
    );

    always_comb begin
        st_d = st_q;
        if (clr_sticky)
            st_d.sticky = 1'b0;
        else if (op_valid && ovf_o)
            st_d.sticky = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sticky_o = st_q.sticky;
endmodule

// File: rtl/pack_arith_chk.sv
module pack_arith_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [3:0]  op_sel,
    input logic [1:0]  lane_fmt,
    input logic        clr_sticky,
    input logic [31:0] res_o,
    input logic        ovf_o,
    input logic        sticky_o
);
    a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ovf_o && !clr_sticky) |=> sticky_o);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_o && !clr_sticky) |=> sticky_o);

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_sticky |=> !sticky_o);

    a_r11_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sticky_o) |-> $past(op_valid && ovf_o));

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel inside {4'd5, 4'd6, 4'd7, 4'd8}) |-> !ovf_o);

    a_r5_word_abs_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd4 && lane_fmt[1]) |-> !res_o[31]);

    a_r7_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel >= 4'd9) |-> (res_o == 32'd0 && !ovf_o));
endmodule

bind pack_arith_unit pack_arith_chk i_pack_arith_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_sel    (op_sel),
    .lane_fmt  (lane_fmt),
    .clr_sticky(clr_sticky),
    .res_o     (res_o),
    .ovf_o     (ovf_o),
    .sticky_o  (sticky_o)
);

// File: tb/test_pack_arith_unit.sv
module test_pack_arith_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic [1:0]  lane_fmt = 2'd0;
    logic [31:0] src_a = 32'd0;
    logic [31:0] src_b = 32'd0;
    logic        clr_sticky = 1'b0;
    logic [31:0] res_o;
    logic        ovf_o;
    logic        sticky_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit sticky_m = 1'b0;

    typedef struct packed {
        logic [31:0] res;
        logic        ovf;
        logic        stk;
        logic [3:0]  op;
        logic [3:0]  req;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    pack_arith_unit i_pack_arith_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_sel    (op_sel),
        .lane_fmt  (lane_fmt),
        .src_a     (src_a),
        .src_b     (src_b),
        .clr_sticky(clr_sticky),
        .res_o     (res_o),
        .ovf_o     (ovf_o),
        .sticky_o  (sticky_o)
    );

    function automatic string req_tag(input logic [3:0] op, input logic [3:0] req);
        if (req == 4'd8) return "R8";
        if (req == 4'd1) return "R1";
        case (op)
            4'd0, 4'd2: return "R2";
            4'd1:       return "R3";
            4'd3:       return "R4";
            4'd4:       return "R5";
            4'd5, 4'd6, 4'd7, 4'd8: return "R6";
            default:    return "R7";
        endcase
    endfunction

    // Integer model of the requirements (R1..R7)
    function automatic void model(input logic [3:0] op, input logic [1:0] fmt,
                                  input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] r, output logic o);
        int  w;
        bit  sg;
        if (fmt[1])      begin w = 32; sg = 1'b1; end
        else if (fmt[0]) begin w = 16; sg = 1'b1; end
        else             begin w = 8;  sg = 1'b0; end
        r = 32'd0;
        o = 1'b0;
        for (int i = 0; i < 32 / w; i++) begin
            longint mask, smax, smin, ua, ub, sa, sb, pa, pb, v;
            logic lo;
            mask = (longint'(1) << w) - 1;
            smax = (longint'(1) << (w - 1)) - 1;
            smin = -(longint'(1) << (w - 1));
            ua = (longint'(a) >> (i * w)) & mask;
            ub = (longint'(b) >> (i * w)) & mask;
            sa = (ua > smax) ? ua - (mask + 1) : ua;
            sb = (ub > smax) ? ub - (mask + 1) : ub;
            pa = sg ? sa : ua;
            pb = sg ? sb : ub;
            lo = 1'b0;
            case (op)
                4'd0, 4'd1: begin
                    v  = pa + pb;
                    lo = sg ? (v > smax || v < smin) : (v > mask);
                    if (op == 4'd1 && lo) v = sg ? ((v > smax) ? smax : smin) : mask;
                end
                4'd2, 4'd3: begin
                    v  = pa - pb;
                    lo = sg ? (v > smax || v < smin) : (v < 0);
                    if (op == 4'd3 && lo) v = sg ? ((v > smax) ? smax : smin) : 0;
                end
                4'd4: begin
                    if (sa == smin) begin v = smax; lo = 1'b1; end
                    else v = (sa < 0) ? -sa : sa;
                end
                4'd5: v = (pa + pb) >>> 1;
                4'd6: v = (pa + pb + 1) >>> 1;
                4'd7: v = (pa - pb) >>> 1;
                4'd8: v = (pa - pb + 1) >>> 1;
                default: v = 0;
            endcase
            r = r | 32'((v & mask) << (i * w));
            o = o | lo;
        end
    endfunction

    task automatic drive(input logic [3:0] op, input logic [1:0] fmt,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic vld, input logic clr, input logic [3:0] req);
        exp_t e;
        logic [31:0] r;
        logic o;
        @(negedge clk);
        op_sel = op; lane_fmt = fmt; src_a = a; src_b = b;
        op_valid = vld; clr_sticky = clr;
        model(op, fmt, a, b, r, o);
        if (clr) sticky_m = 1'b0;
        else if (vld && o) sticky_m = 1'b1;
        e.res = r; e.ovf = o; e.stk = sticky_m; e.op = op; e.req = req;
        sb_q.push_back(e);
    endtask

    // Monitor: combinational outputs due in the drive cycle, sticky one edge later
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks += 3;
            if (res_o !== e.res) begin
                failures++;
                $display("FAIL %s result: actual=%h expected=%h", req_tag(e.op, e.req), res_o, e.res);
            end
            if (ovf_o !== e.ovf) begin
                failures++;
                $display("FAIL %s overflow: actual=%b expected=%b", req_tag(e.op, e.req), ovf_o, e.ovf);
            end
            if (sticky_o !== e.stk) begin
                failures++;
                $display("FAIL R9/R10/R11 sticky: actual=%b expected=%b", sticky_o, e.stk);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;   // R10 reset state
        if (sticky_o !== 1'b0) begin
            failures++;
            $display("FAIL R10 reset sticky: actual=%b expected=0", sticky_o);
        end

        // R2 / R3 unsigned byte carry
        drive(4'd0, 2'd0, 32'h01FF_7F10, 32'h0101_0120, 1'b0, 1'b0, 4'd0);
        drive(4'd1, 2'd0, 32'h01FF_7F10, 32'h0101_0120, 1'b0, 1'b0, 4'd0);
        // R3 signed halfword clamps both ways
        drive(4'd1, 2'd1, 32'h7FFF_8000, 32'h0001_FFFF, 1'b0, 1'b0, 4'd0);
        // R4 word signed and byte unsigned borrow
        drive(4'd3, 2'd2, 32'h8000_0000, 32'h0000_0001, 1'b0, 1'b0, 4'd0);
        drive(4'd3, 2'd0, 32'h0005_0A00, 32'h0106_0101, 1'b0, 1'b0, 4'd0);
        drive(4'd2, 2'd1, 32'h8000_0005, 32'h0001_0003, 1'b0, 1'b0, 4'd0);
        // R5 most negative per format
        drive(4'd4, 2'd0, 32'h80FF_7F01, 32'h0, 1'b0, 1'b0, 4'd0);
        drive(4'd4, 2'd1, 32'h8000_FFFE, 32'h0, 1'b0, 1'b0, 4'd0);
        drive(4'd4, 2'd3, 32'h8000_0000, 32'h0, 1'b0, 1'b0, 4'd0);
        // R6 halving with and without rounding
        drive(4'd5, 2'd1, 32'h0001_7FFF, 32'h0000_7FFF, 1'b0, 1'b0, 4'd0);
        drive(4'd6, 2'd1, 32'h0001_7FFF, 32'h0000_7FFF, 1'b0, 1'b0, 4'd0);
        drive(4'd7, 2'd0, 32'h00FF_0003, 32'hFF00_0100, 1'b0, 1'b0, 4'd0);
        drive(4'd8, 2'd2, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 1'b0, 4'd0);
        // R7 undefined opcode
        drive(4'd12, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'd0);
        // R8 halfword-style carry in byte format does not overflow
        drive(4'd0, 2'd0, 32'h7000_0000, 32'h1000_0000, 1'b1, 1'b0, 4'd8);
        drive(4'd0, 2'd1, 32'h7000_0000, 32'h1000_0000, 1'b0, 1'b0, 4'd8);
        // R1 lane independence: only one lane overflows
        drive(4'd1, 2'd0, 32'h1020_30F0, 32'h0101_0120, 1'b0, 1'b0, 4'd1);
        // R11 overflow without valid leaves sticky clear
        drive(4'd1, 2'd2, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b0, 4'd0);
        // R9 set by wrapping overflow, held by later clean ops
        drive(4'd0, 2'd2, 32'h7FFF_FFFF, 32'h1, 1'b1, 1'b0, 4'd0);
        drive(4'd0, 2'd2, 32'h1, 32'h1, 1'b1, 1'b0, 4'd0);
        drive(4'd5, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'd0);
        // R10 clear beats a simultaneous set
        drive(4'd1, 2'd0, 32'hFF00_0000, 32'h0100_0000, 1'b1, 1'b1, 4'd0);
        drive(4'd0, 2'd0, 32'h0, 32'h0, 1'b0, 1'b0, 4'd0);

        for (int k = 0; k < 400; k++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 9));
            drive(op, 2'($urandom), $urandom, $urandom,
                  1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 15) == 0), 4'd0);
        end

        @(negedge clk);
        op_valid = 1'b0; clr_sticky = 1'b0;
        wait (sb_q.size() == 0);
        @(negedge clk);
        finish_run();
    end
endmodule